// File: doc/BRIEF.md
# Configurable Synchronous Serial Unit

This block is a full-duplex clocked serial port with a data-out pin and a separate data-in pin. Every transfer moves one word out and one word in at the same time. Software loads a word into a transmit holding register and takes the received word from a receive holding register. Both registers have a plain write or read strobe.

The block works in one of two modes. In master mode it drives the serial clock from an internal divider and pulls its own select output low for the length of each word. In slave mode it follows a serial clock and an active-low select that arrive from outside. These two inputs are synchronized into the system clock domain. The clock idle level and the clock phase can each be chosen. A word is 8, 16 or 32 bits long, and its first bit on the wire is either the most significant bit or the least significant bit.

A four-state machine controls each transfer:
- IDLE: no transfer is running. It goes to LEAD when the block is master, the transmit register holds a word and no conflict is flagged. It goes to SLAVE when the block is slave and the select input is low.
- LEAD: the machine waits one half period for the leading clock edge, then goes to TRAIL.
- TRAIL: the machine waits one half period for the trailing clock edge. It then goes back to LEAD, or to IDLE after the last bit.
- SLAVE: the machine follows the external clock. It returns to IDLE when the select input rises or when the mode changes to master.

A conflict sends LEAD or TRAIL straight to IDLE.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, the flags are as follows: transmit empty and transmit end high; receive full, overrun and conflict low; select output high; serial clock output low.
- R2: In master mode a transfer starts once the transmit register holds a word. The select output stays low for the whole transfer. The serial clock rests at the idle level set by `cfg_cpol`, and each half period lasts `cfg_div`+1 system clocks.
- R3: With `cfg_cpha`=0, the block samples input data on the leading clock edge and changes output data on the trailing edge. With `cfg_cpha`=1 it changes output data on the leading edge and samples on the trailing edge. The first output bit is valid before the first leading edge.
- R4: `cfg_width` selects the word length: code 0 gives 8 bits, code 1 gives 16 bits, and codes 2 and 3 give 32 bits. Bits of `tx_data` above the word length are never sent. Bits of `rx_data` above the word length read as zero.
- R5: With `cfg_lsb_first`=1, bit 0 of the word goes first on the wire and the first bit received becomes bit 0. Otherwise the top bit of the word goes first in both directions.
- R6: Writing `tx_data` while transmit empty is high stores the word and clears the flag. A write while the flag is low is ignored and the stored word is kept. The flag returns high when a transfer takes the word.
- R7: Transmit end is high only when no word is being shifted and the transmit register is empty.
- R8: Receive full is set when a word finishes and is cleared by `rx_read`.
- R9: If a word finishes while receive full is set and no read is strobed in that cycle, overrun is set. The new word is dropped and `rx_data` keeps the old word.
- R10: If the select input goes low while in master mode, conflict is set. Any transfer in progress is aborted, both output enables drop, and no new transfer starts until the flag is cleared.
- R11: In slave mode the block loads its transmit word when the select input goes low. It shifts on the external clock and drives data out only while the select input is low. It never drives the serial clock.
- R12: `err_clear` clears overrun and conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1 sends and receives least significant bit first |
| cfg_width | input | 2 | Word length code (0: 8, 1: 16, 2/3: 32) |
| cfg_div | input | DIV_W | Master half period in system clocks, minus one |
| tx_data | input | 32 | Word to transmit |
| tx_write | input | 1 | Strobe that stores tx_data |
| rx_read | input | 1 | Strobe that takes the received word |
| err_clear | input | 1 | Clears overrun and conflict |
| rx_data | output | 32 | Last received word |
| tx_empty | output | 1 | Transmit register is free |
| tx_end | output | 1 | No shift in progress and transmit register empty |
| rx_full | output | 1 | Unread received word present |
| overrun | output | 1 | A received word was dropped |
| conflict | output | 1 | Select input went low while in master mode |
| ser_clk_i | input | 1 | Serial clock from outside (slave mode) |
| ser_clk_o | output | 1 | Serial clock driven in master mode |
| ser_clk_oe | output | 1 | Output enable for ser_clk_o |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out |
| ser_dout_oe | output | 1 | Output enable for ser_dout |
| sel_n_i | input | 1 | Active-low select in: slave select, or a conflict source in master mode |
| sel_n_o | output | 1 | Active-low select driven by the master |

## Verification
The bench builds the block with DIV_W=4 and two synchronizer stages, and runs master transfers with `cfg_div`=1. With these values, 32-bit words finish in about 130 cycles, which makes room to exercise all four clock polarity and phase combinations across every word length and both bit orders. A behavioural peer on the far side of the wire checks both directions of each transfer and measures the half period. The bench also drives the block as a slave, using a slow external clock that the two-stage synchronizer can follow. In these runs it checks that the word is loaded when select falls, that a write to a full transmit register is ignored, and that reception works in both phases.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_SLAVE = 2'd3
    } ssp_state_e;

    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
        unique case (code)
            2'd0:    return CNT_W'(8);
            2'd1:    return CNT_W'(16);
            default: return CNT_W'(32);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] code);
        unique case (code)
            2'd0:    return WORD_W'(32'h0000_00FF);
            2'd1:    return WORD_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

    // Puts a word into wire order (first bit at the top of the active width),
    // or takes it back out. The mapping is its own inverse.
    function automatic logic [WORD_W-1:0] wire_order(input logic [WORD_W-1:0] w,
                                                     input logic [1:0] code,
                                                     input logic lsb_first);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[WORD_W-1-i] = w[i];
        if (lsb_first) r = r >> (CNT_W'(WORD_W) - word_bits(code));
        else           r = w;
        return r & width_mask(code);
    endfunction

endpackage

// File: rtl/ssp_clk_div.sv
module ssp_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || cnt == 0) cnt <= div;
        else                       cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == 0);

    // R2: consecutive half-period ticks are separated when the divider is non-zero
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick && run && div != 0 && $stable(div) |=> !tick);

endmodule

// File: rtl/ssp_in_sync.sv
module ssp_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sel_n_in,
    output logic sclk_s,
    output logic sclk_edge,
    output logic sel_n_s
);
    logic [STAGES:0]   sck_q;
    logic [STAGES-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            sel_q <= '1;
        end else begin
            sck_q <= {sck_q[STAGES-1:0], sclk_in};
            sel_q <= {sel_q[STAGES-2:0], sel_n_in};
        end
    end

    assign sclk_s    = sck_q[STAGES-1];
    assign sclk_edge = sck_q[STAGES] != sck_q[STAGES-1];
    assign sel_n_s   = sel_q[STAGES-1];

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [1:0]        cfg_width,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_write,
    input  logic              rx_read,
    input  logic              err_clear,
    output logic [WORD_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              tx_end,
    output logic              rx_full,
    output logic              overrun,
    output logic              conflict,
    input  logic              ser_clk_i,
    output logic              ser_clk_o,
    output logic              ser_clk_oe,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    input  logic              sel_n_i,
    output logic              sel_n_o
);
    localparam int IDX_W = $clog2(WORD_W);

    ssp_state_e        state, state_nx;
    logic [WORD_W-1:0] tdr, rdr, sr, sr_shifted, rx_word;
    logic [CNT_W-1:0]  bitcnt, nbits;
    logic [IDX_W-1:0]  top_idx;
    logic clk_q, rx_bit, tick, run_div, sclk_s, sclk_edge, sel_s;
    logic conflict_hit, last, lead_ev, trail_ev, do_sample, do_shift;
    logic shift_in, word_done, load;

    ssp_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run_div), .div(cfg_div), .tick(tick)
    );

    ssp_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(ser_clk_i), .sel_n_in(sel_n_i),
        .sclk_s(sclk_s), .sclk_edge(sclk_edge), .sel_n_s(sel_s)
    );

    assign nbits        = word_bits(cfg_width);
    assign top_idx      = IDX_W'(nbits - CNT_W'(1));
    assign last         = bitcnt == nbits - CNT_W'(1);
    assign run_div      = (state == ST_LEAD) || (state == ST_TRAIL);
    assign conflict_hit = cfg_master && !sel_s;

    // Clock edge events, master (divider) or slave (synchronized input)
    assign lead_ev  = (run_div && state == ST_LEAD && tick && !conflict_hit) ||
                      (state == ST_SLAVE && !cfg_master && !sel_s && sclk_edge && sclk_s != cfg_cpol);
    assign trail_ev = (run_div && state == ST_TRAIL && tick && !conflict_hit) ||
                      (state == ST_SLAVE && !cfg_master && !sel_s && sclk_edge && sclk_s == cfg_cpol);

    assign do_sample  = cfg_cpha ? trail_ev : lead_ev;
    assign do_shift   = cfg_cpha ? ((lead_ev && bitcnt != 0) || (trail_ev && last)) : trail_ev;
    assign shift_in   = (cfg_cpha && trail_ev) ? ser_din : rx_bit;
    assign sr_shifted = {sr[WORD_W-2:0], shift_in};
    assign rx_word    = wire_order(sr_shifted, cfg_width, cfg_lsb_first);
    assign word_done  = trail_ev && last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cfg_master && !conflict && !conflict_hit && !tx_empty) state_nx = ST_LEAD;
                else if (!cfg_master && !sel_s)                            state_nx = ST_SLAVE;
            end
            ST_LEAD: begin
                if (conflict_hit)  state_nx = ST_IDLE;
                else if (lead_ev)  state_nx = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (conflict_hit)  state_nx = ST_IDLE;
                else if (trail_ev) state_nx = last ? ST_IDLE : ST_LEAD;
            end
            ST_SLAVE: begin
                if (cfg_master || sel_s) state_nx = ST_IDLE;
            end
        endcase
    end

    assign load = (state == ST_IDLE && state_nx != ST_IDLE) ||
                  (state == ST_SLAVE && state_nx == ST_SLAVE && word_done);

    // Shift engine, holding registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0; bitcnt <= '0; rx_bit <= 1'b0; clk_q <= 1'b0;
            tdr <= '0; tx_empty <= 1'b1; rdr <= '0; rx_full <= 1'b0;
            overrun <= 1'b0; conflict <= 1'b0;
        end else begin
            if (load) begin
                sr     <= tx_empty ? '0 : wire_order(tdr, cfg_width, cfg_lsb_first);
                bitcnt <= '0;
            end else begin
                if (do_shift)          sr     <= sr_shifted;
                if (trail_ev && !last) bitcnt <= bitcnt + 1'b1;
            end
            if (do_sample) rx_bit <= ser_din;

            if (state == ST_IDLE)                         clk_q <= cfg_cpol;
            else if (run_div && (lead_ev || trail_ev))    clk_q <= lead_ev ? !cfg_cpol : cfg_cpol;
            else if (conflict_hit)                        clk_q <= cfg_cpol;

            if (tx_write && tx_empty) begin
                tdr      <= tx_data;
                tx_empty <= 1'b0;
            end else if (load && !tx_empty) begin
                tx_empty <= 1'b1;
            end

            if (word_done) begin
                if (rx_full && !rx_read) overrun <= 1'b1;
                else begin
                    rdr     <= rx_word;
                    rx_full <= 1'b1;
                end
            end else if (rx_read) begin
                rx_full <= 1'b0;
            end
            if (err_clear && !(word_done && rx_full && !rx_read)) overrun <= 1'b0;

            if (conflict_hit)   conflict <= 1'b1;
            else if (err_clear) conflict <= 1'b0;
        end
    end

    // Outputs
    assign rx_data     = rdr;
    assign tx_end      = tx_empty && state == ST_IDLE;
    assign ser_clk_o   = clk_q;
    assign ser_clk_oe  = cfg_master && !conflict;
    assign ser_dout    = sr[top_idx];
    assign ser_dout_oe = cfg_master ? !conflict : (state == ST_SLAVE);
    assign sel_n_o     = !run_div;

    // R4: bit counter stays inside the selected word length while shifting
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE && $stable(cfg_width) |-> bitcnt < nbits);

    // R6: a write to an occupied transmit register leaves it untouched
    a_r6_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write && !tx_empty |=> tdr == $past(tdr));

    // R8: a finished word always leaves receive full set
    a_r8_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> rx_full);

    // R9: an unread word is kept and the overrun flag rises
    a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && rx_full && !rx_read |=> $stable(rdr) && overrun);

    // R10: a flagged conflict in master mode holds the machine in IDLE
    a_r10_conflict_idle: assert property (@(posedge clk) disable iff (!rst_n)
        conflict && cfg_master |=> state == ST_IDLE);

    // R2: the master select output is low whenever the clock leaves its idle level
    a_r2_select_covers_clock: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && $stable(cfg_cpol) && ser_clk_o != cfg_cpol |-> !sel_n_o);

endmodule

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic [3:0]  cfg_div = 4'd1;
    logic [31:0] tx_data = '0;
    logic        tx_write = 1'b0, rx_read = 1'b0, err_clear = 1'b0;
    logic [31:0] rx_data;
    logic        tx_empty, tx_end, rx_full, overrun, conflict;
    logic        ser_clk_i = 1'b0, ser_clk_o, ser_clk_oe, ser_din = 1'b0, ser_dout, ser_dout_oe;
    logic        sel_n_i = 1'b1, sel_n_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_serial_port #(.DIV_W(4), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_width(cfg_width),
        .cfg_div(cfg_div), .tx_data(tx_data), .tx_write(tx_write), .rx_read(rx_read),
        .err_clear(err_clear), .rx_data(rx_data), .tx_empty(tx_empty), .tx_end(tx_end),
        .rx_full(rx_full), .overrun(overrun), .conflict(conflict), .ser_clk_i(ser_clk_i),
        .ser_clk_o(ser_clk_o), .ser_clk_oe(ser_clk_oe), .ser_din(ser_din), .ser_dout(ser_dout),
        .ser_dout_oe(ser_dout_oe), .sel_n_i(sel_n_i), .sel_n_o(sel_n_o)
    );

    // {cpol, cpha, lsb_first, width code, tx word, peer word}
    localparam logic [68:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 32'hDEAD_BEA5, 32'h0000_003C},
        {1'b0, 1'b1, 1'b0, 2'd1, 32'h0000_1234, 32'h0000_8001},
        {1'b1, 1'b0, 1'b1, 2'd0, 32'h0000_0081, 32'h0000_00F0},
        {1'b1, 1'b1, 1'b1, 2'd2, 32'hC001_D00D, 32'h1234_5678},
        {1'b0, 1'b0, 1'b1, 2'd1, 32'hFFFF_A5F0, 32'h0000_0F0F},
        {1'b1, 1'b0, 1'b0, 2'd2, 32'h8000_0001, 32'hFEDC_BA98},
        {1'b0, 1'b1, 1'b1, 2'd0, 32'h0000_0001, 32'h0000_0080},
        {1'b1, 1'b1, 1'b0, 2'd3, 32'h0000_7FFE, 32'h8765_4321}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [1:0] wc);
        return (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    function automatic int posn(input int k, input int n, input logic lsb);
        return lsb ? k : n - 1 - k;
    endfunction

    task automatic pulse_write(input logic [31:0] w);
        tx_data = w; tx_write = 1'b1;
        @(negedge clk); tx_write = 1'b0;
    endtask

    task automatic pulse_read();
        rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
    endtask

    // Master transfer against a behavioural peer on the wire
    task automatic run_master(input logic pol, input logic pha, input logic lsb, input logic [1:0] wc,
                              input logic [31:0] txw, input logic [31:0] peer,
                              input bit do_read, input bit check_rx);
        int n, leads, trails, guard, t_lead, t_trail;
        logic prev, cur;
        logic [31:0] got;
        n = nbits_of(wc);
        @(negedge clk);
        cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_width = wc;
        repeat (2) @(negedge clk);
        ser_din = pha ? 1'b0 : peer[posn(0, n, lsb)];
        pulse_write(txw);
        prev = ser_clk_o; leads = 0; trails = 0; guard = 0; got = '0; t_lead = 0; t_trail = 0;
        while (trails < n && guard < 5000) begin
            @(negedge clk); guard++;
            cur = ser_clk_o;
            if (cur !== prev) begin
                if (cur !== pol) begin
                    if (leads == 0) begin
                        t_lead = cyc;
                        chk("R7 tx_end low while shifting", 32'(tx_end), 32'd0);
                        chk("R2 select low during transfer", 32'(sel_n_o), 32'd0);
                    end
                    got[posn(leads, n, lsb)] = ser_dout;
                    if (pha) ser_din = peer[posn(leads, n, lsb)];
                    leads++;
                end else begin
                    if (trails == 0) t_trail = cyc;
                    if (!pha && trails + 1 < n) ser_din = peer[posn(trails + 1, n, lsb)];
                    trails++;
                end
            end
            prev = cur;
        end
        repeat (2) @(negedge clk);
        chk("R2 half period", 32'(t_trail - t_lead), 32'(cfg_div) + 32'd1);
        chk("R3 R4 R5 transmitted word", got, txw & mask_of(n));
        if (check_rx) begin
            chk("R3 R4 R5 received word", rx_data, peer & mask_of(n));
            chk("R8 receive full set", 32'(rx_full), 32'd1);
        end
        chk("R7 tx_end after last bit", 32'(tx_end), 32'd1);
        chk("R2 clock back at idle level", 32'(ser_clk_o), 32'(pol));
        if (do_read) pulse_read();
    endtask

    // Slave transfer with the bench acting as master
    task automatic run_slave(input logic pol, input logic pha, input logic lsb, input logic [1:0] wc,
                             input logic [31:0] peer, output logic [31:0] got);
        int n;
        n = nbits_of(wc);
        got = '0;
        @(negedge clk);
        cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_width = wc;
        ser_clk_i = pol;
        repeat (4) @(negedge clk);
        sel_n_i = 1'b0;
        if (!pha) ser_din = peer[posn(0, n, lsb)];
        repeat (6) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            if (pha) ser_din = peer[posn(k, n, lsb)];
            else     got[posn(k, n, lsb)] = ser_dout;
            ser_clk_i = ~pol;
            if (k == 0) begin
                chk("R11 data driven while selected", 32'(ser_dout_oe), 32'd1);
                chk("R11 clock never driven as slave", 32'(ser_clk_oe), 32'd0);
            end
            repeat (6) @(negedge clk);
            if (pha) got[posn(k, n, lsb)] = ser_dout;
            ser_clk_i = pol;
            if (!pha && k + 1 < n) ser_din = peer[posn(k + 1, n, lsb)];
            repeat (6) @(negedge clk);
        end
        sel_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] got;
        int guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", 32'(tx_empty), 32'd1);
        chk("R1 tx_end", 32'(tx_end), 32'd1);
        chk("R1 rx_full", 32'(rx_full), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 conflict", 32'(conflict), 32'd0);
        chk("R1 select high", 32'(sel_n_o), 32'd1);
        chk("R1 clock low", 32'(ser_clk_o), 32'd0);

        // Vector table: every phase and polarity, all widths, both orders
        for (int i = 0; i < 8; i++)
            run_master(VEC[i][68], VEC[i][67], VEC[i][66], VEC[i][65:64],
                       VEC[i][63:32], VEC[i][31:0], 1'b1, 1'b1);
        chk("R8 receive full cleared by read", 32'(rx_full), 32'd0);

        // R9 overrun: second word arrives unread
        run_master(1'b0, 1'b0, 1'b0, 2'd0, 32'h11, 32'h96, 1'b0, 1'b1);
        run_master(1'b0, 1'b0, 1'b0, 2'd0, 32'h22, 32'h69, 1'b0, 1'b0);
        chk("R9 overrun set", 32'(overrun), 32'd1);
        chk("R9 old word kept", rx_data, 32'h96);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        chk("R12 overrun cleared", 32'(overrun), 32'd0);
        pulse_read();

        // R10 conflict in master mode
        cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_width = 2'd0;
        sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 conflict set", 32'(conflict), 32'd1);
        chk("R10 clock enable released", 32'(ser_clk_oe), 32'd0);
        chk("R10 data enable released", 32'(ser_dout_oe), 32'd0);
        sel_n_i = 1'b1;
        pulse_write(32'h5A);
        repeat (20) @(negedge clk);
        chk("R10 no transfer while flagged", 32'(sel_n_o), 32'd1);
        chk("R10 word still waiting", 32'(tx_empty), 32'd0);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        chk("R12 conflict cleared", 32'(conflict), 32'd0);
        guard = 0;
        while (!(tx_end && rx_full) && guard < 2000) begin @(negedge clk); guard++; end
        chk("R10 transfer resumes after clear", 32'(rx_full), 32'd1);
        pulse_read();

        // R6 and R11: slave mode, second write ignored
        cfg_master = 1'b0;
        repeat (4) @(negedge clk);
        pulse_write(32'hA7);
        pulse_write(32'h3C);
        chk("R6 register occupied", 32'(tx_empty), 32'd0);
        chk("R11 data released while deselected", 32'(ser_dout_oe), 32'd0);
        run_slave(1'b0, 1'b0, 1'b0, 2'd0, 32'h5A, got);
        chk("R6 first word kept and sent", got, 32'hA7);
        chk("R11 slave received word", rx_data, 32'h5A);
        chk("R6 empty after load", 32'(tx_empty), 32'd1);
        pulse_read();

        pulse_write(32'hBEEF);
        run_slave(1'b1, 1'b1, 1'b1, 2'd1, 32'h1357, got);
        chk("R3 R5 R11 slave sent word", got, 32'hBEEF);
        chk("R3 R5 R11 slave received word", rx_data, 32'h1357);
        pulse_read();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule